// File: doc/BRIEF.md
# Register Scoreboard Hazard Interlock

This block keeps a busy flag for every register of a general register file and holds an instruction at the register-access stage while it would read or overwrite a register whose result has not yet arrived. An instruction that passes register access marks its destination busy. The flag clears when the instruction reaches the execute stage where its unit delivers the result. Early integer results land in the first or second execute stage. Floating-point results land in the fourth. The block carries each issued instruction's destination through an internal stage pipeline tagged with its unit type, so the clear happens at the correct depth without any other input.

Store instructions name their address registers as ordinary sources. Their data register is checked one stage later, in the first execute stage. While that check fails, the store is held there, the stage behind it freezes and a bubble enters the second execute stage. Two down-counters, each steered by a 4-bit selector, count cycles of either kind of stall.

Top module: `reg_scoreboard`

## Requirements
- R1: After synchronous reset, no register is busy, `stall_ra`, `stall_e1` and `ra_issue` are low, and both counters hold `CNT_INIT`.
- R2: With `ra_valid` high and any bit of `ra_src` naming a busy register, `stall_ra` is high and `ra_issue` is low (read-after-write).
- R3: With `ra_valid` high and `ra_dst` naming a busy register, the instruction stalls (write-after-write).
- R4: A passing instruction marks only the registers in `ra_dst`. An all-zero `ra_dst` marks nothing, and an all-zero `ra_src` causes no read-after-write stall.
- R5: `ra_unit` picks the clear stage: code 0 clears at execute stage 1, code 1 at stage 2, codes 2 and 3 at stage 4. A dependent instruction presented in the cycle right after its producer passes therefore stalls 1, 2 or 4 cycles.
- R6: A completion clears only its own destination bit. Other busy bits are unchanged.
- R7: During a stall, `ra_issue` is low, which sends a bubble onward. The held instruction is re-checked each cycle and passes exactly once.
- R8: A store's data register (`ra_sdata`) is checked in execute stage 1. While it is busy, `stall_e1` is high, register access stalls and issues nothing, and the store stays put. A store following a floating-point producer of its data stalls 3 cycles.
- R9: Checks use the registered busy state. A clear lands one cycle after its stage is reached, so it never releases a stall in the same cycle.
- R10: A counter whose selector is 4'b1000 decrements once per cycle with `stall_ra` high. A counter whose selector is 4'b0111 decrements once per cycle with `stall_e1` high. Under any other selector the counter holds its value.
- R11: A set and a clear of different registers in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ra_valid | input | 1 | Instruction present at register access |
| ra_src | input | NREGS | Mask of source registers read at register access |
| ra_dst | input | NREGS | Mask of the destination register (zero if none) |
| ra_unit | input | 2 | Unit type: 0 early integer, 1 late integer, 2/3 floating point |
| ra_sdata | input | NREGS | Mask of a store's data register (zero if not a store) |
| ev_cfg | input | NCNT x 4 | Event selector for each counter |
| stall_ra | output | 1 | Register-access stage is held |
| stall_e1 | output | 1 | Store held in execute stage 1 |
| ra_issue | output | 1 | Instruction passes to execute stage 1 (low means bubble) |
| ev_cnt | output | NCNT x CNT_W | Down-counter values |

## Verification
The bench builds the block with 64 registers, four execute stages, 8-bit counters and a start value of 200. Sixty-four registers make full-width all-ones source masks meaningful against isolated busy bits. Four stages give the floating-point clear its full depth, so the 1/2/4-cycle stall spacing and the 3-cycle store-data stall appear exactly. The small counter start value makes each decrement visible without wrap.

// File: rtl/sb_pkg.sv
package sb_pkg;

  typedef enum logic [1:0] {
    UNIT_INT_EARLY = 2'd0,
    UNIT_INT_LATE  = 2'd1,
    UNIT_FP        = 2'd2,
    UNIT_FP_ALT    = 2'd3
  } unit_e;

  localparam logic [3:0] EVT_RA_STALL = 4'b1000;
  localparam logic [3:0] EVT_E1_STALL = 4'b0111;

  // execute stage (1-based) in which a unit's result becomes final
  function automatic int done_stage(input logic [1:0] u);
    case (u)
      UNIT_INT_EARLY: return 1;
      UNIT_INT_LATE:  return 2;
      default:        return 4;
    endcase
  endfunction

endpackage

// File: rtl/sb_exec_pipe.sv
module sb_exec_pipe
  import sb_pkg::*;
#(
  parameter int NREGS = 64,
  parameter int NSTG  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             in_vld,
  input  logic [1:0]       in_unit,
  input  logic [NREGS-1:0] in_dst,
  input  logic [NREGS-1:0] in_sdata,
  output logic             e1_vld,
  output logic [NREGS-1:0] e1_sdata,
  output logic [NREGS-1:0] clr_mask
);

  logic             vld_q  [NSTG];
  logic [1:0]       unit_q [NSTG];
  logic [NREGS-1:0] dst_q  [NSTG];
  logic [NREGS-1:0] sdata_q;

  // first execute stage: holds while a store waits for its data
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q[0] <= 1'b0;
      sdata_q  <= '0;
    end else if (!hold) begin
      vld_q[0] <= in_vld;
      sdata_q  <= in_vld ? in_sdata : '0;
    end
    if (!hold) begin
      unit_q[0] <= in_unit;
      dst_q[0]  <= in_dst;
    end
  end

  // later stages always advance; stage 2 takes a bubble during a hold
  for (genvar k = 1; k < NSTG; k++) begin : g_stage
    localparam bit TAKES_BUBBLE = (k == 1);
    always_ff @(posedge clk) begin
      if (rst) vld_q[k] <= 1'b0;
      else     vld_q[k] <= vld_q[k-1] & ~(hold & TAKES_BUBBLE);
      unit_q[k] <= unit_q[k-1];
      dst_q[k]  <= dst_q[k-1];
    end
  end

  always_comb begin
    clr_mask = '0;
    for (int k = 0; k < NSTG; k++) begin
      if (vld_q[k] && (done_stage(unit_q[k]) == k + 1)) clr_mask |= dst_q[k];
    end
  end

  assign e1_vld   = vld_q[0];
  assign e1_sdata = sdata_q;

endmodule

// File: rtl/sb_pend_table.sv
module sb_pend_table #(
  parameter int NREGS = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic [NREGS-1:0] set_mask,
  input  logic [NREGS-1:0] clr_mask,
  input  logic [NREGS-1:0] ra_mask,
  input  logic [NREGS-1:0] e1_mask,
  output logic [NREGS-1:0] pend,
  output logic             ra_hit,
  output logic             e1_hit
);

  logic [NREGS-1:0] pend_q;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q & ~clr_mask) | (set_en ? set_mask : '0);
  end

  assign pend   = pend_q;
  assign ra_hit = |(pend_q & ra_mask);
  assign e1_hit = |(pend_q & e1_mask);

endmodule

// File: rtl/sb_event_ctr.sv
module sb_event_ctr
  import sb_pkg::*;
#(
  parameter int               CNT_W    = 16,
  parameter logic [CNT_W-1:0] CNT_INIT = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       cfg,
  input  logic             ev_ra,
  input  logic             ev_e1,
  output logic [CNT_W-1:0] cnt
);

  logic dec;

  assign dec = ((cfg == EVT_RA_STALL) && ev_ra) || ((cfg == EVT_E1_STALL) && ev_e1);

  always_ff @(posedge clk) begin
    if (rst)      cnt <= CNT_INIT;
    else if (dec) cnt <= cnt - 1'b1;
  end

endmodule

// File: rtl/reg_scoreboard.sv
module reg_scoreboard #(
  parameter int               NREGS    = 64,
  parameter int               NSTG     = 4,
  parameter int               NCNT     = 2,
  parameter int               CNT_W    = 16,
  parameter logic [CNT_W-1:0] CNT_INIT = '1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       ra_valid,
  input  logic [NREGS-1:0]           ra_src,
  input  logic [NREGS-1:0]           ra_dst,
  input  logic [1:0]                 ra_unit,
  input  logic [NREGS-1:0]           ra_sdata,
  input  logic [NCNT-1:0][3:0]       ev_cfg,
  output logic                       stall_ra,
  output logic                       stall_e1,
  output logic                       ra_issue,
  output logic [NCNT-1:0][CNT_W-1:0] ev_cnt
);

  logic [NREGS-1:0] pend;
  logic [NREGS-1:0] clr_mask;
  logic [NREGS-1:0] e1_sdata;
  logic             e1_vld;
  logic             ra_hit;
  logic             e1_hit;

  sb_exec_pipe #(.NREGS(NREGS), .NSTG(NSTG)) u_pipe (
    .clk      (clk),
    .rst      (rst),
    .hold     (stall_e1),
    .in_vld   (ra_issue),
    .in_unit  (ra_unit),
    .in_dst   (ra_dst),
    .in_sdata (ra_sdata),
    .e1_vld   (e1_vld),
    .e1_sdata (e1_sdata),
    .clr_mask (clr_mask)
  );

  sb_pend_table #(.NREGS(NREGS)) u_pend (
    .clk      (clk),
    .rst      (rst),
    .set_en   (ra_issue),
    .set_mask (ra_dst),
    .clr_mask (clr_mask),
    .ra_mask  (ra_src | ra_dst),
    .e1_mask  (e1_sdata),
    .pend     (pend),
    .ra_hit   (ra_hit),
    .e1_hit   (e1_hit)
  );

  assign stall_e1 = e1_vld & e1_hit;
  assign stall_ra = ra_valid & (ra_hit | stall_e1);
  assign ra_issue = ra_valid & ~ra_hit & ~stall_e1;

  for (genvar c = 0; c < NCNT; c++) begin : g_ctr
    sb_event_ctr #(.CNT_W(CNT_W), .CNT_INIT(CNT_INIT)) u_ctr (
      .clk   (clk),
      .rst   (rst),
      .cfg   (ev_cfg[c]),
      .ev_ra (stall_ra),
      .ev_e1 (stall_e1),
      .cnt   (ev_cnt[c])
    );
  end

endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
  parameter int NREGS = 64,
  parameter int NCNT  = 2,
  parameter int CNT_W = 16
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       ra_valid,
  input logic [NREGS-1:0]           ra_src,
  input logic [NREGS-1:0]           ra_dst,
  input logic                       stall_ra,
  input logic                       stall_e1,
  input logic                       ra_issue,
  input logic [NREGS-1:0]           pend,
  input logic [NREGS-1:0]           clr_mask,
  input logic [NCNT-1:0][CNT_W-1:0] ev_cnt
);

  a_r1_reset_clears: assert property (@(posedge clk) rst |=> (pend == '0));

  a_r2_raw_blocks: assert property (@(posedge clk) disable iff (rst)
    (ra_valid && |(pend & ra_src)) |-> (stall_ra && !ra_issue));

  a_r3_waw_blocks: assert property (@(posedge clk) disable iff (rst)
    (ra_valid && |(pend & ra_dst)) |-> (stall_ra && !ra_issue));

  a_r4_issue_marks_dst: assert property (@(posedge clk) disable iff (rst)
    ra_issue |=> ((pend & $past(ra_dst)) == $past(ra_dst)));

  a_r7_stall_no_issue: assert property (@(posedge clk) disable iff (rst)
    stall_ra |-> !ra_issue);

  a_r8_e1_freezes_ra: assert property (@(posedge clk) disable iff (rst)
    stall_e1 |-> !ra_issue);

  a_r10_idle_cnt_hold: assert property (@(posedge clk) disable iff (rst)
    (!stall_ra && !stall_e1) |=> $stable(ev_cnt));

  a_r11_set_clr_disjoint: assert property (@(posedge clk) disable iff (rst)
    !(ra_issue && |(ra_dst & clr_mask)));

endmodule

bind reg_scoreboard sb_checker #(.NREGS(NREGS), .NCNT(NCNT), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ra_valid (ra_valid),
  .ra_src   (ra_src),
  .ra_dst   (ra_dst),
  .stall_ra (stall_ra),
  .stall_e1 (stall_e1),
  .ra_issue (ra_issue),
  .pend     (pend),
  .clr_mask (clr_mask),
  .ev_cnt   (ev_cnt)
);

// File: tb/reg_scoreboard_bench.sv
module reg_scoreboard_bench;

  localparam int             NR   = 64;
  localparam int             CW   = 8;
  localparam logic [CW-1:0]  INIT = 8'd200;

  logic               clk = 1'b0;
  logic               rst;
  logic               ra_valid;
  logic [NR-1:0]      ra_src, ra_dst, ra_sdata;
  logic [1:0]         ra_unit;
  logic [1:0][3:0]    ev_cfg;
  logic               stall_ra, stall_e1, ra_issue;
  logic [1:0][CW-1:0] ev_cnt;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  reg_scoreboard #(.NREGS(NR), .NSTG(4), .NCNT(2), .CNT_W(CW), .CNT_INIT(INIT)) u_reg_scoreboard (
    .clk(clk), .rst(rst), .ra_valid(ra_valid), .ra_src(ra_src), .ra_dst(ra_dst),
    .ra_unit(ra_unit), .ra_sdata(ra_sdata), .ev_cfg(ev_cfg),
    .stall_ra(stall_ra), .stall_e1(stall_e1), .ra_issue(ra_issue), .ev_cnt(ev_cnt)
  );

  function automatic logic [NR-1:0] bit_of(input int r);
    logic [NR-1:0] m = '0;
    m[r] = 1'b1;
    return m;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // called at a negedge; presents one instruction until it passes
  task automatic issue(input logic [NR-1:0] src, input logic [NR-1:0] dst,
                       input logic [NR-1:0] sd, input logic [1:0] unit,
                       output int n_ra, output int n_e1, output int bad_bub);
    n_ra = 0; n_e1 = 0; bad_bub = 0;
    ra_valid = 1'b1; ra_src = src; ra_dst = dst; ra_sdata = sd; ra_unit = unit;
    for (int i = 0; i < 32; i++) begin
      #1;
      if (stall_e1) n_e1++;
      if (ra_issue) begin
        if (stall_ra) bad_bub++;
        break;
      end
      n_ra++;
      if (!stall_ra) bad_bub++;
      @(negedge clk);
    end
    @(negedge clk);
    ra_valid = 1'b0; ra_src = '0; ra_dst = '0; ra_sdata = '0; ra_unit = 2'd0;
  endtask

  task automatic t_reset;
    int a, b, c;
    #1;
    chk("R1 stall_ra after reset", int'(stall_ra), 0);
    chk("R1 stall_e1 after reset", int'(stall_e1), 0);
    chk("R1 ra_issue after reset", int'(ra_issue), 0);
    chk("R1 cnt0 after reset", int'(ev_cnt[0]), int'(INIT));
    chk("R1 cnt1 after reset", int'(ev_cnt[1]), int'(INIT));
    @(negedge clk);
    issue('1, bit_of(5), '0, 2'd0, a, b, c);
    chk("R1 all registers free after reset", a, 0);
    idle(6);
  endtask

  task automatic t_latency;
    int a, b, c;
    int exp_st[4] = '{1, 2, 4, 4};
    for (int u = 0; u < 4; u++) begin
      issue('0, bit_of(10), '0, 2'(u), a, b, c);
      issue(bit_of(10), bit_of(20), '0, 2'd0, a, b, c);
      chk($sformatf("R5 R2 R9 raw stall cycles unit %0d", u), a, exp_st[u]);
      chk($sformatf("R7 bubble while held unit %0d", u), c, 0);
      idle(6);
    end
  endtask

  task automatic t_waw;
    int a, b, c;
    issue('0, bit_of(7), '0, 2'd2, a, b, c);
    issue('0, bit_of(7), '0, 2'd0, a, b, c);
    chk("R3 waw stall cycles", a, 4);
    chk("R7 waw bubble", c, 0);
    idle(6);
  endtask

  task automatic t_no_dst;
    int a, b, c;
    issue('0, bit_of(3), '0, 2'd2, a, b, c);
    issue(bit_of(4), bit_of(5), '0, 2'd0, a, b, c);
    chk("R4 unrelated registers stay free", a, 0);
    idle(6);
    issue('0, '0, '0, 2'd2, a, b, c);
    issue('1, bit_of(9), '0, 2'd0, a, b, c);
    chk("R4 zero destination marks nothing", a, 0);
    idle(6);
  endtask

  task automatic t_isolation;
    int a, b, c;
    issue('0, bit_of(1), '0, 2'd2, a, b, c);
    issue('0, bit_of(2), '0, 2'd0, a, b, c);
    chk("R6 independent write passes", a, 0);
    issue(bit_of(2), bit_of(9), '0, 2'd0, a, b, c);
    chk("R6 early result released alone", a, 1);
    issue(bit_of(1), bit_of(11), '0, 2'd0, a, b, c);
    chk("R6 late result still busy", a, 1);
    idle(6);
  endtask

  task automatic t_set_clear;
    int a, b, c;
    issue('0, bit_of(2), '0, 2'd0, a, b, c);
    issue('0, bit_of(8), '0, 2'd0, a, b, c);
    issue(bit_of(2) | bit_of(8), '0, '0, 2'd0, a, b, c);
    chk("R11 set and clear both applied", a, 1);
    idle(6);
  endtask

  task automatic t_store;
    int a, b, c;
    int c0, c1;
    ev_cfg[0] = 4'b1000; ev_cfg[1] = 4'b0111;
    idle(1);
    #1; c0 = int'(ev_cnt[0]); c1 = int'(ev_cnt[1]);
    @(negedge clk);
    issue('0, bit_of(12), '0, 2'd2, a, b, c);
    issue(bit_of(13), '0, bit_of(12), 2'd0, a, b, c);
    chk("R8 store address check passes", a, 0);
    issue(bit_of(14), bit_of(15), '0, 2'd0, a, b, c);
    chk("R8 e1 stall cycles", b, 3);
    chk("R8 ra frozen behind store", a, 3);
    chk("R7 store-freeze bubble", c, 0);
    idle(6);
    #1;
    chk("R10 ra-stall counter", int'(ev_cnt[0]), c0 - 3);
    chk("R10 e1-stall counter", int'(ev_cnt[1]), c1 - 3);
    @(negedge clk);
    issue('0, '0, bit_of(30), 2'd0, a, b, c);
    issue('0, bit_of(31), '0, 2'd0, a, b, c);
    chk("R8 clean store data no e1 stall", b, 0);
    chk("R8 clean store no ra stall", a, 0);
    idle(6);
  endtask

  task automatic t_cfg_other;
    int a, b, c;
    int c0, c1;
    ev_cfg[0] = 4'b0000; ev_cfg[1] = 4'b1111;
    idle(1);
    #1; c0 = int'(ev_cnt[0]); c1 = int'(ev_cnt[1]);
    @(negedge clk);
    issue('0, bit_of(40), '0, 2'd2, a, b, c);
    issue(bit_of(40), '0, '0, 2'd0, a, b, c);
    idle(6);
    #1;
    chk("R10 unselected code holds cnt0", int'(ev_cnt[0]), c0);
    chk("R10 unselected code holds cnt1", int'(ev_cnt[1]), c1);
    @(negedge clk);
    ev_cfg[0] = 4'b1000; ev_cfg[1] = 4'b0111;
    issue('0, bit_of(41), '0, 2'd3, a, b, c);
    issue(bit_of(41), '0, '0, 2'd0, a, b, c);
    idle(6);
    #1;
    chk("R10 ra counter counts raw stalls", int'(ev_cnt[0]), c0 - 4);
    chk("R10 e1 counter ignores ra stalls", int'(ev_cnt[1]), c1);
    @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; ra_valid = 1'b0; ra_src = '0; ra_dst = '0; ra_sdata = '0;
    ra_unit = 2'd0; ev_cfg = '0;
    idle(3);
    rst = 1'b0;
    t_reset();
    t_latency();
    t_waw();
    t_no_dst();
    t_isolation();
    t_set_clear();
    t_store();
    t_cfg_other();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule